// File: doc/BRIEF.md
# Octal DDR Memory Bus Transaction Master

This block turns one host request at a time into a complete transaction on an 8-line double-data-rate memory bus. The bus has four signals: an active-low chip select, a bus clock, the shared data lines, and a strobe that the memory returns during reads. A transaction has three phases. First, a 48-bit command-address word goes out, one byte per clock edge. Next comes a wait phase whose length is programmable. Last comes a data phase of one or more 16-bit words. The host supplies a byte address inside a mapped window, the direction, the target space (memory array or registers), the burst kind and a word count. Write words are pulled from the host one at a time, and each read word is returned with a valid pulse.

The design runs on one core clock at twice the bus-clock rate. Each core cycle is one bus-clock edge: in the core cycles where the bus clock is high, a byte goes out on a rising edge, and in the cycles where it is low, a byte goes out on a falling edge. Read bytes are not timed by the controller's own clock. The block takes a byte whenever the sampled memory strobe changes level, so a memory that stalls its strobe only stretches the data phase. After each transaction, chip select stays high for a programmable number of cycles before the next request can be taken.

Top module: `obus_master`

## Requirements
- R1: Command-address bit 47 is 1 for a read and 0 for a write, bit 46 is 1 for register space and 0 for the memory array, and bit 45 is 1 for a linear burst and 0 for a wrapped burst.
- R2: The word address is (byte address - BASE_ADDR) >> 1. Command-address bits 44:16 carry word-address bits 31:3, bits 15:3 are zero, and bits 2:0 carry word-address bits 2:0.
- R3: The six command-address bytes go out most significant byte first, one per core cycle, starting in the first cycle of chip select low. The bus clock is high in cycles 0, 2 and 4 of the low period and low in cycles 1, 3 and 5.
- R4: The data phase starts exactly 6 + 2*latency_i core cycles after chip select falls. A latency of 0 is allowed.
- R5: A write sends req_words_m1_i+1 words, each with the high byte while the bus clock is high and the low byte in the next cycle while it is low. wdata_ready_o pulses once per word, and wdata_i is taken in the cycle of that pulse.
- R6: During a read, each change of bus_ds_i in either direction captures one byte of bus_dq_i, high byte first. Cycles with no strobe change add no byte. Each pair of bytes is delivered as rdata_o with a one-cycle rdata_valid_o.
- R7: Chip select stays low through the whole transaction and for 2 core cycles after the last data byte. The bus clock is low in those 2 cycles and whenever chip select is high. done_o pulses once per transaction.
- R8: After chip select rises, req_ready_o stays low for exactly cs_gap_i cycles. req_ready_o is never high while chip select is low.
- R9: During reset, chip select is high, the bus clock is low, the output enable is low and req_ready_o is high.
- R10: bus_dq_oe_o is high only during the command-address phase and the write data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, two bus-clock edges per bus period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_reg_i | input | 1 | 1 = register space, 0 = memory array |
| req_linear_i | input | 1 | 1 = linear burst, 0 = wrapped burst |
| req_addr_i | input | ADDR_W | Host byte address in the mapped window |
| req_words_m1_i | input | LEN_W | Number of 16-bit words minus one |
| latency_i | input | LAT_W | Wait phase length in bus-clock periods |
| cs_gap_i | input | GAP_W | Minimum chip-select-high cycles before the next request |
| wdata_i | input | 16 | Write word |
| wdata_ready_o | output | 1 | Write word taken this cycle |
| rdata_o | output | 16 | Read word |
| rdata_valid_o | output | 1 | Read word valid |
| done_o | output | 1 | Transaction data phase complete |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_ck_o | output | 1 | Bus clock |
| bus_dq_o | output | 8 | Data lines out |
| bus_dq_oe_o | output | 1 | Data lines output enable |
| bus_dq_i | input | 8 | Data lines in |
| bus_ds_i | input | 1 | Read strobe from the memory |

## Verification
The bench covers a zero-length wait phase, a long wait, single-word and multi-word bursts, and reads in which the memory delays its first strobe edge and also pauses in the middle of the burst. A design that counted bytes per cycle instead of per strobe change would return shifted or duplicated words on the paused reads. One that packed the address without the window offset or the halving would show wrong bits 44:16 and 2:0, and a byte-order swap would show up as reversed write bytes. Chip-select length and the ready gap are measured cycle by cycle, so an off-by-one in the tail or gap counters is reported.

// File: rtl/obus_pkg.sv
package obus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CA, ST_WAIT, ST_WDATA, ST_RDATA, ST_TAIL, ST_GAP
  } obus_st_e;

  localparam int CA_BYTES = 6;
endpackage

// File: rtl/obus_ca_pack.sv
module obus_ca_pack #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000
) (
  input  logic              wr_i,
  input  logic              reg_i,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [47:0]       ca_o
);
  logic [ADDR_W-1:0] off;
  logic [31:0]       wa;

  assign off  = addr_i - BASE_ADDR[ADDR_W-1:0];
  assign wa   = 32'(off >> 1);
  assign ca_o = {~wr_i, reg_i, linear_i, wa[31:3], 13'd0, wa[2:0]};
endmodule

// File: rtl/obus_rd_capture.sv
module obus_rd_capture (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        ds_i,
  input  logic [7:0]  dq_i,
  output logic        edge_o,
  output logic [15:0] word_o,
  output logic        word_vld_o
);
  logic       ds_q;
  logic       ph_q;
  logic [7:0] hi_q;

  assign edge_o = en_i && (ds_i != ds_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ds_q       <= 1'b0;
      ph_q       <= 1'b0;
      hi_q       <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      ds_q       <= ds_i;
      word_vld_o <= 1'b0;
      if (!en_i) begin
        ph_q <= 1'b0;
      end else if (edge_o) begin
        ph_q <= ~ph_q;
        if (!ph_q) hi_q <= dq_i;
        else begin
          word_o     <= {hi_q, dq_i};
          word_vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/obus_master.sv
module obus_master
  import obus_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h8000_0000,
  parameter int          LEN_W     = 8,
  parameter int          LAT_W     = 4,
  parameter int          GAP_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_reg_i,
  input  logic              req_linear_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_words_m1_i,
  input  logic [LAT_W-1:0]  latency_i,
  input  logic [GAP_W-1:0]  cs_gap_i,
  input  logic [15:0]       wdata_i,
  output logic              wdata_ready_o,
  output logic [15:0]       rdata_o,
  output logic              rdata_valid_o,
  output logic              done_o,
  output logic              bus_cs_no,
  output logic              bus_ck_o,
  output logic [7:0]        bus_dq_o,
  output logic              bus_dq_oe_o,
  input  logic [7:0]        bus_dq_i,
  input  logic              bus_ds_i
);
  localparam int MAX_A = (LEN_W > LAT_W) ? LEN_W : LAT_W;
  localparam int MAX_W = (MAX_A > GAP_W) ? MAX_A : GAP_W;
  localparam int CNT_W = MAX_W + 2;
  localparam logic [CNT_W-1:0] CA_LAST = CNT_W'(CA_BYTES - 1);

  obus_st_e         st_q;
  logic [47:0]      ca_w, ca_sr;
  logic [CNT_W-1:0] cnt_q;
  logic             tog_q, wr_q;
  logic [LEN_W-1:0] n_q;
  logic [LAT_W-1:0] lat_q;
  logic [GAP_W-1:0] gap_q;
  logic [15:0]      wbuf_q;
  logic             rd_edge;
  logic [CNT_W-1:0] byte_last, wait_last, gap_last;
  logic             active, data_st;

  obus_ca_pack #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ca (
    .wr_i(req_write_i), .reg_i(req_reg_i), .linear_i(req_linear_i),
    .addr_i(req_addr_i), .ca_o(ca_w)
  );

  obus_rd_capture u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(st_q == ST_RDATA),
    .ds_i(bus_ds_i), .dq_i(bus_dq_i), .edge_o(rd_edge),
    .word_o(rdata_o), .word_vld_o(rdata_valid_o)
  );

  assign byte_last = CNT_W'({n_q, 1'b1});
  assign wait_last = CNT_W'({lat_q, 1'b0}) - CNT_W'(1);
  assign gap_last  = CNT_W'(gap_q) - CNT_W'(1);
  assign data_st   = wr_q ? 1'b1 : 1'b0;
  assign active    = (st_q == ST_CA) || (st_q == ST_WAIT) ||
                     (st_q == ST_WDATA) || (st_q == ST_RDATA);

  assign req_ready_o = (st_q == ST_IDLE);
  assign bus_cs_no   = (st_q == ST_IDLE) || (st_q == ST_GAP);
  assign bus_ck_o    = active && !tog_q;
  assign bus_dq_oe_o = (st_q == ST_CA) || (st_q == ST_WDATA);
  assign done_o      = (st_q == ST_TAIL) && (cnt_q == '0);

  always_comb begin
    unique case (st_q)
      ST_CA:    bus_dq_o = ca_sr[47:40];
      ST_WDATA: bus_dq_o = cnt_q[0] ? wbuf_q[7:0] : wbuf_q[15:8];
      default:  bus_dq_o = 8'h00;
    endcase
  end

  // fetch next word one cycle ahead of its high byte
  assign wdata_ready_o = wr_q && (
      ((st_q == ST_CA) && (cnt_q == CA_LAST) && (lat_q == '0)) ||
      ((st_q == ST_WAIT) && (cnt_q == wait_last)) ||
      ((st_q == ST_WDATA) && cnt_q[0] && (cnt_q != byte_last)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ca_sr  <= '0;
      cnt_q  <= '0;
      tog_q  <= 1'b0;
      wr_q   <= 1'b0;
      n_q    <= '0;
      lat_q  <= '0;
      gap_q  <= '0;
      wbuf_q <= '0;
    end else begin
      if (wdata_ready_o) wbuf_q <= wdata_i;
      if (active) tog_q <= ~tog_q;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          ca_sr <= ca_w;
          wr_q  <= req_write_i;
          n_q   <= req_words_m1_i;
          lat_q <= latency_i;
          gap_q <= cs_gap_i;
          cnt_q <= '0;
          tog_q <= 1'b0;
          st_q  <= ST_CA;
        end
        ST_CA: begin
          ca_sr <= {ca_sr[39:0], 8'h00};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CA_LAST) begin
            cnt_q <= '0;
            if (lat_q != '0) st_q <= ST_WAIT;
            else             st_q <= data_st ? ST_WDATA : ST_RDATA;
          end
        end
        ST_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == wait_last) begin
            cnt_q <= '0;
            st_q  <= data_st ? ST_WDATA : ST_RDATA;
          end
        end
        ST_WDATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == byte_last) begin
            cnt_q <= '0;
            st_q  <= ST_TAIL;
          end
        end
        ST_RDATA: if (rd_edge) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == byte_last) begin
            cnt_q <= '0;
            st_q  <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            cnt_q <= '0;
            st_q  <= (gap_q == '0) ? ST_IDLE : ST_GAP;
          end
        end
        ST_GAP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == gap_last) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/obus_master_chk.sv
module obus_master_chk #(
  parameter int GAP_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [GAP_W-1:0] cs_gap_i,
  input logic             rdata_valid_o,
  input logic             bus_cs_no,
  input logic             bus_ck_o,
  input logic             bus_dq_oe_o
);
  logic [GAP_W-1:0] gap_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_cap <= '0;
    else if (req_valid_i && req_ready_o) gap_cap <= cs_gap_i;
  end

  assert_oe_in_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dq_oe_o |-> !bus_cs_no);

  assert_ready_cs_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> bus_cs_no);

  assert_gap_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bus_cs_no) && (gap_cap != '0)) |-> !req_ready_o);

  assert_first_edge_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_cs_no) |-> bus_ck_o);

  assert_ck_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_no |-> !bus_ck_o);

  assert_rvalid_in_txn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> !bus_cs_no);
endmodule

bind obus_master obus_master_chk #(.GAP_W(GAP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .cs_gap_i(cs_gap_i),
  .rdata_valid_o(rdata_valid_o), .bus_cs_no(bus_cs_no),
  .bus_ck_o(bus_ck_o), .bus_dq_oe_o(bus_dq_oe_o)
);

// File: tb/sim_obus_master.sv
`timescale 1ns/1ps
module sim_obus_master;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h8000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_reg = 0, req_linear = 0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_words_m1 = '0;
  logic [3:0]  latency = '0, cs_gap = '0;
  logic [15:0] wdata;
  logic        req_ready, wdata_ready, rdata_valid, done;
  logic [15:0] rdata;
  logic        cs_n, ck, oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = '0;
  logic        ds = 1'b0;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obus_master #(.BASE_ADDR(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_reg_i(req_reg), .req_linear_i(req_linear),
    .req_addr_i(req_addr), .req_words_m1_i(req_words_m1), .latency_i(latency),
    .cs_gap_i(cs_gap), .wdata_i(wdata), .wdata_ready_o(wdata_ready),
    .rdata_o(rdata), .rdata_valid_o(rdata_valid), .done_o(done),
    .bus_cs_no(cs_n), .bus_ck_o(ck), .bus_dq_o(dq_o), .bus_dq_oe_o(oe),
    .bus_dq_i(dq_i), .bus_ds_i(ds)
  );

  // transaction context
  logic        cur_wr;
  int          cur_lat, cur_nw, cur_stall, cur_mid;
  logic [15:0] wq [8];
  logic [15:0] rdw [8];
  logic [15:0] rcap [8];
  logic [7:0]  ca_b [6];
  logic [7:0]  wb [16];
  int          widx, rc, k, rs, cs_len, gap_cnt, wrdy_cnt, done_cnt;
  logic        wpend, gap_on, gap_done, ck_bad, oe_bad, was_low;

  assign wdata = wq[widx[2:0]];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (wpend) widx++;
    wpend = wdata_ready;
    if (wdata_ready) wrdy_cnt++;
    if (done) done_cnt++;
    if (rdata_valid && rc < 8) begin rcap[rc] = rdata; rc++; end
    if (!cs_n) begin
      int ds0, de, hold_k;
      ds0 = 6 + 2*cur_lat;
      de  = ds0 + (cur_wr ? 2*cur_nw : 0);
      if (k < 6) ca_b[k] = dq_o;
      if (k < de && ck !== ((k % 2) == 0)) ck_bad = 1;
      if (oe !== ((k < 6) || (cur_wr && k >= ds0 && k < de))) oe_bad = 1;
      if (cur_wr && k >= ds0 && k < de) wb[k-ds0] = dq_o;
      hold_k = (cur_mid != 0) ? ds0 + cur_stall + cur_mid : -1;
      if (!cur_wr && k >= ds0 + cur_stall && k != hold_k && rs < 2*cur_nw) begin
        ds   = ~ds;
        dq_i = rs[0] ? rdw[rs/2][7:0] : rdw[rs/2][15:8];
        rs++;
      end
      k++;
      was_low = 1;
    end else begin
      if (was_low) begin
        cs_len = k; k = 0; gap_on = 1; gap_cnt = 0; was_low = 0;
      end
      if (gap_on) begin
        if (req_ready) begin gap_on = 0; gap_done = 1; end
        else gap_cnt++;
      end
    end
  end

  function automatic logic [47:0] exp_ca(input logic wr, input logic rg, input logic ln,
                                         input logic [31:0] a);
    logic [31:0] w;
    w = (a - BASE) >> 1;
    return {~wr, rg, ln, w[31:3], 13'd0, w[2:0]};
  endfunction

  task automatic run_txn(input logic wr, input logic rg, input logic ln, input logic [31:0] a,
                         input int nw, input int lat, input int gap, input int stall,
                         input int mid);
    cur_wr = wr; cur_lat = lat; cur_nw = nw; cur_stall = stall; cur_mid = mid;
    widx = 0; wpend = 0; rc = 0; rs = 0; wrdy_cnt = 0; done_cnt = 0;
    gap_done = 0; ck_bad = 0; oe_bad = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_reg = rg; req_linear = ln; req_addr = a;
    req_words_m1 = 8'(nw - 1); latency = 4'(lat); cs_gap = 4'(gap);
    @(negedge clk);
    req_valid = 0;
    while (!gap_done) @(negedge clk);
  endtask

  task automatic check_common(input logic wr, input logic rg, input logic ln,
                              input logic [31:0] a, input int gap);
    logic [47:0] got, exp;
    got = {ca_b[0], ca_b[1], ca_b[2], ca_b[3], ca_b[4], ca_b[5]};
    exp = exp_ca(wr, rg, ln, a);
    chk("R1 ca flags", 64'(got[47:45]), 64'(exp[47:45]));
    chk("R2 ca address", 64'(got[44:0]), 64'(exp[44:0]));
    chk("R3 ck pattern", 64'(ck_bad), 64'(0));
    chk("R10 output enable", 64'(oe_bad), 64'(0));
    chk("R7 done pulses", 64'(done_cnt), 64'(1));
    chk("R8 ready gap", 64'(gap_cnt), 64'(gap));
  endtask

  task automatic t_write(input logic rg, input logic ln, input logic [31:0] a,
                         input int nw, input int lat, input int gap);
    for (int i = 0; i < 8; i++) wq[i] = 16'hA000 + 16'(i * 16'h0111) + 16'(nw);
    run_txn(1'b1, rg, ln, a, nw, lat, gap, 0, 0);
    check_common(1'b1, rg, ln, a, gap);
    for (int i = 0; i < nw; i++) begin
      chk("R5 write high byte", 64'(wb[2*i]), 64'(wq[i][15:8]));
      chk("R5 write low byte", 64'(wb[2*i+1]), 64'(wq[i][7:0]));
    end
    chk("R5 wdata_ready pulses", 64'(wrdy_cnt), 64'(nw));
    chk("R4 R7 cs low length", 64'(cs_len), 64'(6 + 2*lat + 2*nw + 2));
  endtask

  task automatic t_read(input logic rg, input logic ln, input logic [31:0] a,
                        input int nw, input int lat, input int gap, input int stall,
                        input int mid);
    for (int i = 0; i < 8; i++) rdw[i] = 16'h3C00 + 16'(i * 16'h1357) + 16'(stall);
    run_txn(1'b0, rg, ln, a, nw, lat, gap, stall, mid);
    check_common(1'b0, rg, ln, a, gap);
    chk("R6 read word count", 64'(rc), 64'(nw));
    for (int i = 0; i < nw; i++) chk("R6 read word", 64'(rcap[i]), 64'(rdw[i]));
    chk("R4 R7 cs low length", 64'(cs_len),
        64'(6 + 2*lat + stall + 2*nw + ((mid != 0) ? 1 : 0) + 2));
  endtask

  task automatic t_reset;
    #1;
    chk("R9 reset cs high", 64'(cs_n), 64'(1));
    chk("R9 reset ck low", 64'(ck), 64'(0));
    chk("R9 reset oe low", 64'(oe), 64'(0));
    chk("R9 reset ready", 64'(req_ready), 64'(1));
  endtask

  initial begin
    k = 0; was_low = 0; gap_on = 0; gap_done = 0; widx = 0; wpend = 0;
    cur_wr = 0; cur_lat = 0; cur_nw = 1; cur_stall = 0; cur_mid = 0;
    rc = 0; rs = 0; wrdy_cnt = 0; done_cnt = 0; ck_bad = 0; oe_bad = 0;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_write(1'b0, 1'b1, BASE + 32'h0000_1234, 2, 2, 3);
    t_read(1'b1, 1'b0, BASE + 32'h7FFE_FFF6, 3, 0, 0, 0, 0);
    t_read(1'b0, 1'b1, BASE + 32'h0012_3458, 1, 5, 5, 3, 1);
    t_read(1'b0, 1'b1, BASE + 32'h0000_00AE, 4, 1, 2, 2, 3);
    t_write(1'b1, 1'b0, BASE + 32'h0ABC_DEF0, 4, 0, 1);
    t_write(1'b0, 1'b0, BASE, 1, 15, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule